// File: doc/BRIEF.md
# Cascadable Timer Counter Pair with High-Byte Read Latch

The block holds two up-counters of equal width on a small register port. With `cascade` low they are two independent timers. Each one steps on its own count tick while its run control is high. With `cascade` high they form one counter of twice the width. The first counter is the lower half and the second counter is the upper half. The upper half steps only when the lower half rolls over.

A write to a counter register always sets it to zero, and the write data is discarded. A write is honoured only while the governing timer is fully stopped, meaning both its run control and its status flag are low. In chained mode the lower timer's controls govern both counters. A write that arrives while the governing timer is busy changes nothing and sets a sticky fault flag.

Reading the lower half in chained mode copies the upper half into a holding latch. A following read of the upper register returns that copy, so software that reads low then high gets one coherent value.

The register port is a plain single-cycle access port with no valid/ready handshake. Every access completes in the cycle it is presented and never applies back-pressure. Read data is combinational from the current state and `bus_sel`.

Top module: `tmr_pair`

## Requirements
- R1: After an active-low asynchronous reset, both counters, the high-byte latch, both status flags and `wr_fault` are 0.
- R2: In separate mode, a write with `bus_sel`=0 clears counter 0 and a write with `bus_sel`=1 clears counter 1, provided that counter is stopped. The write data has no effect, and the other counter is left unchanged.
- R3: In chained mode, a write to either `bus_sel` value clears both counters, provided timer 0 is stopped.
- R4: A write while the governing timer's run or status bit is 1 leaves every counter unchanged and sets `wr_fault` to 1. `wr_fault` stays 1 until reset. Timer 0 governs both counters in chained mode.
- R5: `stat[i]` equals `run[i]` delayed by one clock.
- R6: In separate mode, counter i increases by 1 on each clock where `run[i]` and `tick[i]` are both 1, wraps from all-ones to 0, and is not affected by the other timer.
- R7: In chained mode, counter 0 steps on `run[0]` and `tick[0]`, and counter 1 steps only when counter 0 wraps. The pair wraps from all-ones to 0, and `run[1]`/`tick[1]` have no effect.
- R8: `bus_rdata` returns counter 0 for `bus_sel`=0. In chained mode, a cycle with `bus_rd`=1 and `bus_sel`=0 copies counter 1 into the latch, and `bus_sel`=1 returns the latch. In separate mode, `bus_sel`=1 returns the live counter 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cascade | input | 1 | 1 = chained double-width mode, 0 = two separate timers |
| run | input | 2 | Run control per timer (bit 0 = timer 0) |
| tick | input | 2 | Count-enable tick per timer |
| stat | output | 2 | Status flag per timer, run delayed one clock |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives latch capture) |
| bus_sel | input | 1 | Register select: 0 = counter 0, 1 = counter 1 |
| bus_wdata | input | W | Write data, discarded |
| bus_rdata | output | W | Read data for the selected register |
| wr_fault | output | 1 | Sticky flag for a write refused while busy |

## Verification
The embedded properties assume that `cascade` changes only while both timers are stopped. They also assume that `run` and `tick` are held steady for whole cycles, with all inputs driven low during reset. The stimulus changes inputs only on the falling clock edge and switches `cascade` only after the status flags have dropped. It exercises refused writes only in the final scenario, so that the sticky fault flag does not hide earlier results.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_N     = 2;
  localparam int unsigned SEL_LO    = 0;
  localparam int unsigned SEL_HI    = 1;
  typedef enum logic {MODE_SPLIT = 1'b0, MODE_CHAIN = 1'b1} tmr_mode_e;
endpackage

// File: rtl/tmr_ctl.sv
module tmr_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic stat,
  output logic idle
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= 1'b0;
    else        stat <= run;
  end

  assign idle = !run && !stat;

  AST_STAT_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |=> stat); // R5
  AST_STAT_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |=> !stat); // R5
endmodule

// File: rtl/tmr_cnt.sv
module tmr_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign wrap = inc && (cnt == ALL_ONES);

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> cnt == W'($past(cnt) + 1'b1)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt)); // R6
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cascade,
  input  logic [1:0]   run,
  input  logic [1:0]   tick,
  output logic [1:0]   stat,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic         bus_sel,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         wr_fault
);
  logic [TMR_N-1:0] idle_v, clr_v, inc_v, wrap_v;
  logic [W-1:0]     cnt_v [TMR_N];
  logic [W-1:0]     hi_latch;
  logic             chain, wr_ok, busy_wr, cap_hi;
  logic             data_unused;

  assign chain       = (tmr_mode_e'(cascade) == MODE_CHAIN);
  assign data_unused = ^bus_wdata;

  for (genvar i = 0; i < TMR_N; i++) begin : g_tmr
    tmr_ctl u_ctl (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run[i]),
      .stat (stat[i]),
      .idle (idle_v[i])
    );
    tmr_cnt #(.W(W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr_v[i]),
      .inc  (inc_v[i]),
      .cnt  (cnt_v[i]),
      .wrap (wrap_v[i])
    );
  end

  // write gating: timer 0 governs both counters when chained
  always_comb begin
    if (chain) wr_ok = idle_v[SEL_LO];
    else       wr_ok = bus_sel ? idle_v[SEL_HI] : idle_v[SEL_LO];
    busy_wr = bus_wr && !wr_ok;
    clr_v[SEL_LO] = bus_wr && wr_ok && (chain || !bus_sel);
    clr_v[SEL_HI] = bus_wr && wr_ok && (chain ||  bus_sel);
  end

  assign inc_v[SEL_LO] = run[SEL_LO] && tick[SEL_LO];
  assign inc_v[SEL_HI] = chain ? wrap_v[SEL_LO] : (run[SEL_HI] && tick[SEL_HI]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wr_fault <= 1'b0;
    else if (busy_wr) wr_fault <= 1'b1;
  end

  assign cap_hi = chain && bus_rd && !bus_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_latch <= '0;
    else if (cap_hi) hi_latch <= cnt_v[SEL_HI];
  end

  always_comb begin
    if (!bus_sel)   bus_rdata = cnt_v[SEL_LO];
    else if (chain) bus_rdata = hi_latch;
    else            bus_rdata = cnt_v[SEL_HI];
  end

  AST_BUSY_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_sel && (run[0] || stat[0])) |=> wr_fault); // R4
  AST_BUSY_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (run[0] || stat[0]) && !inc_v[SEL_LO] && (chain || !bus_sel))
      |=> $stable(cnt_v[SEL_LO])); // R4
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fault |=> wr_fault); // R4
  AST_HI_ON_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (chain && !wrap_v[SEL_LO] && !clr_v[SEL_HI]) |=> $stable(cnt_v[SEL_HI])); // R7
  AST_LATCH_GRAB: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hi |=> hi_latch == $past(cnt_v[SEL_HI])); // R8
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_hi |=> $stable(hi_latch)); // R8
endmodule

// File: tb/tmr_pair_tb.sv
module tmr_pair_tb;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cascade = 1'b0;
  logic [1:0] run = '0, tick = '0, stat;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0, wr_fault;
  logic [W-1:0] bus_wdata = '0, bus_rdata;
  int vecs = 0, errs = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_pair #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cascade(cascade), .run(run), .tick(tick),
    .stat(stat), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_fault(wr_fault)
  );

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [W-1:0] val);
    @(negedge clk); bus_sel = sel; bus_rd = 1'b1;
    #1 val = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [W-1:0] d);
    @(negedge clk); bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic count(input logic [1:0] r, input logic [1:0] t, input int n);
    @(negedge clk); run = r; tick = t;
    repeat (n) @(negedge clk);
    run = '0; tick = '0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    chk("R1 stat", stat, 0);
    chk("R1 fault", wr_fault, 0);
    rd(1'b0, v); chk("R1 cnt0", v, 0);
    rd(1'b1, v); chk("R1 cnt1", v, 0);
  endtask

  task automatic t_split_count();
    logic [W-1:0] v;
    @(negedge clk); run = 2'b11; tick = 2'b11;
    #1 chk("R5 stat lags rise", stat, 0);
    repeat (3) @(negedge clk);
    chk("R5 stat high", stat, 3);
    tick = 2'b01;
    repeat (2) @(negedge clk);
    run = '0; tick = '0;
    #1 chk("R5 stat still high", stat, 3);
    @(negedge clk);
    chk("R5 stat low", stat, 0);
    rd(1'b0, v); chk("R6 cnt0", v, 5);
    rd(1'b1, v); chk("R6 cnt1", v, 3);
    wr(1'b0, 8'hA5);
    rd(1'b0, v); chk("R2 cnt0 cleared", v, 0);
    rd(1'b1, v); chk("R2 cnt1 kept", v, 3);
    wr(1'b1, 8'hFF);
    rd(1'b1, v); chk("R2 cnt1 cleared", v, 0);
  endtask

  task automatic t_split_wrap();
    logic [W-1:0] v;
    count(2'b01, 2'b01, 259);
    rd(1'b0, v); chk("R6 wrap cnt0", v, 3);
    rd(1'b1, v); chk("R6 cnt1 independent", v, 0);
  endtask

  task automatic t_chain_latch();
    logic [W-1:0] v;
    @(negedge clk); cascade = 1'b1;
    wr(1'b0, 8'h77);
    rd(1'b0, v); chk("R3 chain clear", v, 0);
    count(2'b11, 2'b11, 300);
    rd(1'b0, v); chk("R7 low byte", v, 8'h2C);
    rd(1'b1, v); chk("R8 latched high", v, 8'h01);
    count(2'b01, 2'b01, 256);
    rd(1'b1, v); chk("R8 latch holds", v, 8'h01);
    rd(1'b0, v); chk("R7 low byte again", v, 8'h2C);
    rd(1'b1, v); chk("R8 fresh latch", v, 8'h02);
    @(negedge clk); cascade = 1'b0;
    rd(1'b1, v); chk("R8 split live high", v, 8'h02);
    @(negedge clk); cascade = 1'b1;
  endtask

  task automatic t_chain_clear();
    logic [W-1:0] v;
    wr(1'b1, 8'h5A);
    rd(1'b0, v); chk("R3 low cleared by high write", v, 0);
    rd(1'b1, v); chk("R3 high cleared", v, 0);
  endtask

  task automatic t_chain_wrap();
    logic [W-1:0] v;
    count(2'b01, 2'b01, 65541);
    rd(1'b0, v); chk("R7 pair wrap low", v, 5);
    rd(1'b1, v); chk("R7 pair wrap high", v, 0);
  endtask

  task automatic t_busy_write();
    logic [W-1:0] v;
    chk("R4 fault clear before", wr_fault, 0);
    @(negedge clk); run = 2'b01; tick = 2'b00;
    wr(1'b1, 8'h00);
    chk("R4 fault set", wr_fault, 1);
    rd(1'b0, v); chk("R4 running write ignored", v, 5);
    @(negedge clk); run = 2'b00; bus_sel = 1'b0; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(1'b0, v); chk("R4 status window write ignored", v, 5);
    wr(1'b0, 8'h12);
    rd(1'b0, v); chk("R3 stopped write clears", v, 0);
    chk("R4 fault sticky", wr_fault, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_split_count();
    t_split_wrap();
    t_chain_latch();
    t_chain_clear();
    t_chain_wrap();
    t_busy_write();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule